// File: doc/BRIEF.md
# Directory DMA Coherence Controller

This block is the DMA-facing part of a memory-side directory. It keeps a small per-line state record for a set of directory-tracked lines. It accepts DMA reads and DMA writes on the same request channel that cache ownership requests use. When a line has no cached owner, the controller goes straight to the memory controller. A DMA read becomes a line fetch. A DMA write becomes a partial writeback whose byte enables come from the address offset and the length. When a line is held modified by a single cache, the controller first sends that owner an invalidate and collects its dirty copy. It then writes the line back in full. For a read, it forwards the recalled data to the DMA engine. For a write, it merges the pending DMA bytes over the recalled data before the writeback.

Each finished DMA transaction ends with one response on the outgoing response channel: DATA carries a whole line, and ACK marks a completed write. Invalidates to owners leave on the same outgoing channel. A request that the current line state cannot take is handed back through a recycle strobe, so the external queue re-presents it later. A single transaction buffer holds the bytes of a DMA write that is waiting for an owner recall.

Top module: `dir_dma_top`

## Requirements
- R1: After reset every line is invalid with no owner, the transaction buffer is free, and neither the response channel nor the memory channel presents a valid beat.
- R2: An ownership request (reqKind 0) to an invalid line is accepted, makes the requester (reqOwner) the modified owner and produces no output. An ownership request to any line that is not invalid is recycled.
- R3: A DMA read (reqKind 1) to an invalid line is accepted and, one cycle later, issues a memory read (memReqWrite 0, memReqBe all zero) for that line. The next memory data response for the line (memRspAck 0) produces, one cycle later, a DATA response (outKind 0) carrying the full returned line, and the line is invalid again.
- R4: A DMA write (reqKind 2) to an invalid line is accepted and, one cycle later, issues a partial memory writeback. Bytes outside the enables are driven as zero. The memory acknowledgement (memRspAck 1) produces, one cycle later, an ACK response (outKind 1), and the line returns to invalid.
- R5: The partial-write byte enables set bit b exactly when offset <= b < offset + length, with the offset taken from the low reqAddr bits and the enables clipped at the end of the line. A length of zero gives no enabled byte.
- R6: A DMA read to a modified line is accepted and sends an INV (outKind 2) to the recorded owner (outDest). The owner's data response then produces, one cycle later, a DATA response with that data and a full-line writeback with all enables set. The following memory acknowledgement gives no output and leaves the line invalid with no owner.
- R7: A DMA write to a modified line stores the data, offset and length in the transaction buffer and sends an INV to the owner. The owner's data response produces a full-line writeback in which the enabled DMA bytes replace the recalled bytes. The memory acknowledgement then produces an ACK and frees the buffer.
- R8: Only one transaction buffer exists. A DMA write to a modified line while the buffer is held is recycled. Once the buffer is freed, the same write is accepted.
- R9: Every valid request gets, in the same cycle, exactly one of reqAccept or reqRecycle. A request to a line in a transient state, or with the unused code reqKind 3, is recycled.
- R10: A memory response that emits an output owns the response channel in its cycle. A request that needs that channel is recycled, and an owner response that needs it is stalled (rspReady low). An owner response that is taken owns the memory channel, so a request needing memory in that cycle is recycled.
- R11: An owner response or memory response for a line whose state does not expect it is consumed without any output or state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present at queue head |
| reqKind | input | 2 | 0 ownership, 1 DMA read, 2 DMA write, 3 unused |
| reqAddr | input | IDX_W+OFF_W (5) | Line index in upper bits, byte offset in lower OFF_W bits |
| reqLen | input | LEN_W (4) | DMA write length in bytes |
| reqData | input | LINE_W (64) | DMA write data, line aligned |
| reqOwner | input | OWNER_W (2) | Requesting cache id for ownership requests |
| reqAccept | output | 1 | Request consumed this cycle |
| reqRecycle | output | 1 | Request returned to the back of the queue |
| rspValid | input | 1 | Owner data response present |
| rspLine | input | IDX_W (2) | Line of the owner response |
| rspData | input | LINE_W (64) | Recalled line data |
| rspReady | output | 1 | Owner response consumed this cycle |
| memRspValid | input | 1 | Memory response present |
| memRspAck | input | 1 | 1 writeback acknowledgement, 0 read data |
| memRspLine | input | IDX_W (2) | Line of the memory response |
| memRspData | input | LINE_W (64) | Memory read data |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | 1 writeback, 0 fetch |
| memReqLine | output | IDX_W (2) | Line of the memory request |
| memReqData | output | LINE_W (64) | Writeback data |
| memReqBe | output | LINE_BYTES (8) | Writeback byte enables |
| outValid | output | 1 | Outgoing response valid |
| outKind | output | 2 | 0 DATA, 1 ACK, 2 INV |
| outLine | output | IDX_W (2) | Line of the outgoing response |
| outData | output | LINE_W (64) | Line data for DATA |
| outDest | output | OWNER_W (2) | Owner id for INV, zero otherwise |

## Verification
The main collision is between a memory response and a request or owner response in the same cycle. A memory response that must answer the DMA engine takes the single outgoing response slot. The bench provokes this in two ways. First, it presents a memory data return for one line while a DMA read to a modified line asks for an INV. Second, it presents a memory data return alongside an owner recall for a read. It judges the result by the recycle strobe, by rspReady dropping, and by the registered output the next cycle carrying the memory data rather than the other event. A second pairing puts an owner recall on the memory port in the same cycle as a DMA write to an invalid line. Here the write must be recycled while the full-line writeback of the recalled data goes out.

// File: rtl/dir_dma_pkg.sv
package dir_dma_pkg;

  typedef enum logic [1:0] {
    KIND_OWN    = 2'd0,
    KIND_DMA_RD = 2'd1,
    KIND_DMA_WR = 2'd2,
    KIND_RSVD   = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    OUT_DATA = 2'd0,
    OUT_ACK  = 2'd1,
    OUT_INV  = 2'd2
  } outKind_e;

  typedef enum logic [2:0] {
    LS_I,
    LS_M,
    LS_ID,
    LS_IDW,
    LS_MRD,
    LS_MRDI,
    LS_MWR,
    LS_MWRI
  } lineState_e;

  typedef enum logic [1:0] {
    OSRC_NONE,
    OSRC_MEM,
    OSRC_OWNER
  } outSrc_e;

  typedef enum logic [1:0] {
    MSRC_READ,
    MSRC_PARTIAL,
    MSRC_OWNER,
    MSRC_MERGED
  } memSrc_e;

  typedef struct packed {
    logic     outFire;
    outKind_e outKind;
    outSrc_e  outSrc;
    logic     memFire;
    logic     memWrite;
    memSrc_e  memSrc;
    logic     tbeLoad;
  } dpStrobe_t;

endpackage

// File: rtl/dir_dma_ctrl.sv
module dir_dma_ctrl
  import dir_dma_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int OWNER_W   = 2,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic               reqAccept,
  output logic               reqRecycle,
  input  logic               rspValid,
  input  logic [IDX_W-1:0]   rspIdx,
  output logic               rspReady,
  input  logic               memRspValid,
  input  logic               memRspAck,
  input  logic [IDX_W-1:0]   memRspIdx,
  output dpStrobe_t          strobe,
  output logic [IDX_W-1:0]   outIdx,
  output logic [OWNER_W-1:0] outDest,
  output logic [IDX_W-1:0]   memIdx
);

  lineState_e         lineState [NUM_LINES];
  logic [OWNER_W-1:0] lineOwner [NUM_LINES];
  logic               tbeBusy;

  lineState_e memSt, rspSt, reqSt, reqNext;
  reqKind_e   kind;

  assign memSt = lineState[memRspIdx];
  assign rspSt = lineState[rspIdx];
  assign reqSt = lineState[reqIdx];
  assign kind  = reqKind_e'(reqKind);

  // memory response decode
  logic     memTake, memEmits, memFreesTbe;
  outKind_e memOutKind;

  always_comb begin
    memTake     = 1'b0;
    memEmits    = 1'b0;
    memFreesTbe = 1'b0;
    memOutKind  = OUT_DATA;
    if (memRspValid) begin
      case (memSt)
        LS_ID: if (!memRspAck) begin
          memTake = 1'b1; memEmits = 1'b1; memOutKind = OUT_DATA;
        end
        LS_IDW: if (memRspAck) begin
          memTake = 1'b1; memEmits = 1'b1; memOutKind = OUT_ACK;
        end
        LS_MRDI: if (memRspAck) memTake = 1'b1;
        LS_MWRI: if (memRspAck) begin
          memTake = 1'b1; memEmits = 1'b1; memOutKind = OUT_ACK; memFreesTbe = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // owner response decode
  logic rspMatch, rspIsRead, rspStall, rspTake;
  assign rspMatch  = rspValid && (rspSt == LS_MRD || rspSt == LS_MWR);
  assign rspIsRead = (rspSt == LS_MRD);
  assign rspStall  = rspMatch && rspIsRead && memEmits;
  assign rspTake   = rspMatch && !rspStall;
  assign rspReady  = rspValid && !rspStall;

  // request decode
  logic reqOk, reqNeedMem, reqNeedOut;
  always_comb begin
    reqOk      = 1'b0;
    reqNeedMem = 1'b0;
    reqNeedOut = 1'b0;
    reqNext    = reqSt;
    case (kind)
      KIND_OWN: if (reqSt == LS_I) begin
        reqOk = 1'b1; reqNext = LS_M;
      end
      KIND_DMA_RD: begin
        if (reqSt == LS_I) begin
          reqOk = 1'b1; reqNeedMem = 1'b1; reqNext = LS_ID;
        end else if (reqSt == LS_M) begin
          reqOk = 1'b1; reqNeedOut = 1'b1; reqNext = LS_MRD;
        end
      end
      KIND_DMA_WR: begin
        if (reqSt == LS_I) begin
          reqOk = 1'b1; reqNeedMem = 1'b1; reqNext = LS_IDW;
        end else if (reqSt == LS_M && !tbeBusy) begin
          reqOk = 1'b1; reqNeedOut = 1'b1; reqNext = LS_MWR;
        end
      end
      default: ;
    endcase
  end

  logic outBusy, memBusy;
  assign outBusy    = memEmits || (rspTake && rspIsRead);
  assign memBusy    = rspTake;
  assign reqAccept  = reqValid && reqOk && !(reqNeedMem && memBusy) && !(reqNeedOut && outBusy);
  assign reqRecycle = reqValid && !reqAccept;

  // strobes to the datapath
  always_comb begin
    strobe  = '{outFire: 1'b0, outKind: OUT_DATA, outSrc: OSRC_NONE, memFire: 1'b0,
                memWrite: 1'b0, memSrc: MSRC_READ, tbeLoad: 1'b0};
    outIdx  = '0;
    outDest = '0;
    memIdx  = '0;
    if (memEmits) begin
      strobe.outFire = 1'b1;
      strobe.outKind = memOutKind;
      strobe.outSrc  = (memOutKind == OUT_DATA) ? OSRC_MEM : OSRC_NONE;
      outIdx         = memRspIdx;
    end
    if (rspTake) begin
      strobe.memFire  = 1'b1;
      strobe.memWrite = 1'b1;
      strobe.memSrc   = rspIsRead ? MSRC_OWNER : MSRC_MERGED;
      memIdx          = rspIdx;
      if (rspIsRead) begin
        strobe.outFire = 1'b1;
        strobe.outKind = OUT_DATA;
        strobe.outSrc  = OSRC_OWNER;
        outIdx         = rspIdx;
      end
    end
    if (reqAccept) begin
      if (reqNeedMem) begin
        strobe.memFire  = 1'b1;
        strobe.memWrite = (kind == KIND_DMA_WR);
        strobe.memSrc   = (kind == KIND_DMA_WR) ? MSRC_PARTIAL : MSRC_READ;
        memIdx          = reqIdx;
      end
      if (reqNeedOut) begin
        strobe.outFire = 1'b1;
        strobe.outKind = OUT_INV;
        strobe.outSrc  = OSRC_NONE;
        outIdx         = reqIdx;
        outDest        = lineOwner[reqIdx];
        strobe.tbeLoad = (kind == KIND_DMA_WR);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        lineState[i] <= LS_I;
        lineOwner[i] <= '0;
      end
      tbeBusy <= 1'b0;
    end else begin
      if (memTake) begin
        lineState[memRspIdx] <= LS_I;
        lineOwner[memRspIdx] <= '0;
      end
      if (memFreesTbe) tbeBusy <= 1'b0;
      if (rspTake) lineState[rspIdx] <= rspIsRead ? LS_MRDI : LS_MWRI;
      if (reqAccept) begin
        lineState[reqIdx] <= reqNext;
        if (kind == KIND_OWN) lineOwner[reqIdx] <= reqOwner;
      end
      if (strobe.tbeLoad) tbeBusy <= 1'b1;
    end
  end

endmodule

// File: rtl/dir_dma_datapath.sv
module dir_dma_datapath
  import dir_dma_pkg::*;
#(
  parameter int LINE_BYTES = 8,
  parameter int OWNER_W    = 2,
  parameter int IDX_W      = 2,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int LEN_W      = $clog2(LINE_BYTES) + 1,
  parameter int LINE_W     = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [IDX_W-1:0]      outIdx,
  input  logic [OWNER_W-1:0]    outDest,
  input  logic [IDX_W-1:0]      memIdx,
  input  logic [OFF_W-1:0]      reqOffset,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [LINE_W-1:0]     reqData,
  input  logic [LINE_W-1:0]     rspData,
  input  logic [LINE_W-1:0]     memRspData,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [IDX_W-1:0]      memReqLine,
  output logic [LINE_W-1:0]     memReqData,
  output logic [LINE_BYTES-1:0] memReqBe,
  output logic                  outValid,
  output logic [1:0]            outKind,
  output logic [IDX_W-1:0]      outLine,
  output logic [LINE_W-1:0]     outData,
  output logic [OWNER_W-1:0]    outDest_q
);

  logic [LINE_BYTES-1:0] reqBe;
  logic [LINE_W-1:0]     maskedReq;
  logic [LINE_W-1:0]     mergedLine;
  logic [LINE_BYTES-1:0] tbeBe;
  logic [LINE_W-1:0]     tbeData;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign reqBe[b] = (int'(reqOffset) <= b) && (b < int'(reqOffset) + int'(reqLen));
    assign maskedReq[b*8 +: 8]  = reqBe[b] ? reqData[b*8 +: 8] : 8'h00;
    assign mergedLine[b*8 +: 8] = tbeBe[b] ? tbeData[b*8 +: 8] : rspData[b*8 +: 8];
  end

  // single transaction buffer for a write awaiting recall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbeBe   <= '0;
      tbeData <= '0;
    end else if (strobe.tbeLoad) begin
      tbeBe   <= reqBe;
      tbeData <= reqData;
    end
  end

  logic [LINE_W-1:0]     memDataNext;
  logic [LINE_BYTES-1:0] memBeNext;
  logic [LINE_W-1:0]     outDataNext;

  always_comb begin
    case (strobe.memSrc)
      MSRC_PARTIAL: begin memDataNext = maskedReq;  memBeNext = reqBe; end
      MSRC_OWNER:   begin memDataNext = rspData;    memBeNext = '1;    end
      MSRC_MERGED:  begin memDataNext = mergedLine; memBeNext = '1;    end
      default:      begin memDataNext = '0;         memBeNext = '0;    end
    endcase
    case (strobe.outSrc)
      OSRC_MEM:   outDataNext = memRspData;
      OSRC_OWNER: outDataNext = rspData;
      default:    outDataNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memReqWrite <= 1'b0;
      memReqLine  <= '0;
      memReqData  <= '0;
      memReqBe    <= '0;
      outValid    <= 1'b0;
      outKind     <= '0;
      outLine     <= '0;
      outData     <= '0;
      outDest_q   <= '0;
    end else begin
      memReqValid <= strobe.memFire;
      memReqWrite <= strobe.memFire && strobe.memWrite;
      memReqLine  <= strobe.memFire ? memIdx : '0;
      memReqData  <= strobe.memFire ? memDataNext : '0;
      memReqBe    <= strobe.memFire ? memBeNext : '0;
      outValid    <= strobe.outFire;
      outKind     <= strobe.outFire ? strobe.outKind : OUT_DATA;
      outLine     <= strobe.outFire ? outIdx : '0;
      outData     <= strobe.outFire ? outDataNext : '0;
      outDest_q   <= strobe.outFire ? outDest : '0;
    end
  end

endmodule

// File: rtl/dir_dma_top.sv
module dir_dma_top
  import dir_dma_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int OWNER_W    = 2,
  parameter int IDX_W      = $clog2(NUM_LINES),
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int LEN_W      = $clog2(LINE_BYTES) + 1,
  parameter int LINE_W     = LINE_BYTES * 8,
  parameter int ADDR_W     = IDX_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [LINE_W-1:0]     reqData,
  input  logic [OWNER_W-1:0]    reqOwner,
  output logic                  reqAccept,
  output logic                  reqRecycle,
  input  logic                  rspValid,
  input  logic [IDX_W-1:0]      rspLine,
  input  logic [LINE_W-1:0]     rspData,
  output logic                  rspReady,
  input  logic                  memRspValid,
  input  logic                  memRspAck,
  input  logic [IDX_W-1:0]      memRspLine,
  input  logic [LINE_W-1:0]     memRspData,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [IDX_W-1:0]      memReqLine,
  output logic [LINE_W-1:0]     memReqData,
  output logic [LINE_BYTES-1:0] memReqBe,
  output logic                  outValid,
  output logic [1:0]            outKind,
  output logic [IDX_W-1:0]      outLine,
  output logic [LINE_W-1:0]     outData,
  output logic [OWNER_W-1:0]    outDest
);

  dpStrobe_t          strobe;
  logic [IDX_W-1:0]   outIdx, memIdx;
  logic [OWNER_W-1:0] destSel;

  dir_dma_ctrl #(
    .NUM_LINES(NUM_LINES), .OWNER_W(OWNER_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqIdx     (reqAddr[ADDR_W-1:OFF_W]),
    .reqOwner   (reqOwner),
    .reqAccept  (reqAccept),
    .reqRecycle (reqRecycle),
    .rspValid   (rspValid),
    .rspIdx     (rspLine),
    .rspReady   (rspReady),
    .memRspValid(memRspValid),
    .memRspAck  (memRspAck),
    .memRspIdx  (memRspLine),
    .strobe     (strobe),
    .outIdx     (outIdx),
    .outDest    (destSel),
    .memIdx     (memIdx)
  );

  dir_dma_datapath #(
    .LINE_BYTES(LINE_BYTES), .OWNER_W(OWNER_W), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .LEN_W(LEN_W), .LINE_W(LINE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .outIdx     (outIdx),
    .outDest    (destSel),
    .memIdx     (memIdx),
    .reqOffset  (reqAddr[OFF_W-1:0]),
    .reqLen     (reqLen),
    .reqData    (reqData),
    .rspData    (rspData),
    .memRspData (memRspData),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite),
    .memReqLine (memReqLine),
    .memReqData (memReqData),
    .memReqBe   (memReqBe),
    .outValid   (outValid),
    .outKind    (outKind),
    .outLine    (outLine),
    .outData    (outData),
    .outDest_q  (outDest)
  );

endmodule

// File: rtl/dir_dma_checker.sv
module dir_dma_checker #(
  parameter int LINE_BYTES = 8,
  parameter int OWNER_W    = 2,
  parameter int IDX_W      = 2,
  parameter int LEN_W      = 4,
  parameter int LINE_W     = 64,
  parameter int ADDR_W     = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [1:0]            reqKind,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic [LEN_W-1:0]      reqLen,
  input logic [LINE_W-1:0]     reqData,
  input logic [OWNER_W-1:0]    reqOwner,
  input logic                  reqAccept,
  input logic                  reqRecycle,
  input logic                  rspValid,
  input logic [IDX_W-1:0]      rspLine,
  input logic [LINE_W-1:0]     rspData,
  input logic                  rspReady,
  input logic                  memRspValid,
  input logic                  memRspAck,
  input logic [IDX_W-1:0]      memRspLine,
  input logic [LINE_W-1:0]     memRspData,
  input logic                  memReqValid,
  input logic                  memReqWrite,
  input logic [IDX_W-1:0]      memReqLine,
  input logic [LINE_W-1:0]     memReqData,
  input logic [LINE_BYTES-1:0] memReqBe,
  input logic                  outValid,
  input logic [1:0]            outKind,
  input logic [IDX_W-1:0]      outLine,
  input logic [LINE_W-1:0]     outData,
  input logic [OWNER_W-1:0]    outDest
);

  a_r9_one_decision: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAccept ^ reqRecycle));

  a_r9_no_decision_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqAccept && !reqRecycle));

  a_r3_fetch_origin: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (memReqBe == '0 && $past(reqAccept && reqKind == 2'd1)));

  a_r6_inv_origin: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd2) |-> $past(reqAccept));

  a_r7_ack_origin: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd1) |-> $past(memRspValid && memRspAck));

  a_r10_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> memRspValid);

  a_r6_full_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && !$past(reqAccept)) |-> (&memReqBe));

endmodule

bind dir_dma_top dir_dma_checker #(
  .LINE_BYTES(LINE_BYTES), .OWNER_W(OWNER_W), .IDX_W(IDX_W),
  .LEN_W(LEN_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_dir_dma_top.sv
`timescale 1ns/1ps
module test_dir_dma_top;

  localparam int LB = 8;
  localparam int LW = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0;
  logic [1:0]  reqKind = 0;
  logic [4:0]  reqAddr = 0;
  logic [3:0]  reqLen = 0;
  logic [63:0] reqData = 0;
  logic [1:0]  reqOwner = 0;
  logic        reqAccept, reqRecycle;
  logic        rspValid = 0;
  logic [1:0]  rspLine = 0;
  logic [63:0] rspData = 0;
  logic        rspReady;
  logic        memRspValid = 0;
  logic        memRspAck = 0;
  logic [1:0]  memRspLine = 0;
  logic [63:0] memRspData = 0;
  logic        memReqValid, memReqWrite;
  logic [1:0]  memReqLine;
  logic [63:0] memReqData;
  logic [7:0]  memReqBe;
  logic        outValid;
  logic [1:0]  outKind;
  logic [1:0]  outLine;
  logic [63:0] outData;
  logic [1:0]  outDest;

  always #5 clk = ~clk;

  dir_dma_top i_dir_dma_top (.*);

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic gotAcc, gotRec, gotRdy;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [7:0] seed);
    logic [63:0] v;
    for (int i = 0; i < LB; i++) v[i*8 +: 8] = seed + 8'(i * 17);
    return v;
  endfunction

  function automatic logic [7:0] expBe(input int off, input int len);
    logic [7:0] b;
    for (int i = 0; i < LB; i++) b[i] = (i >= off) && (i < off + len);
    return b;
  endfunction

  function automatic logic [63:0] maskBytes(input logic [63:0] d, input logic [7:0] be, input logic [63:0] other);
    logic [63:0] v;
    for (int i = 0; i < LB; i++) v[i*8 +: 8] = be[i] ? d[i*8 +: 8] : other[i*8 +: 8];
    return v;
  endfunction

  // one cycle of stimulus on any combination of the three input channels
  task automatic step(input bit rv, input int kind, input int idx, input int off, input int len,
                      input logic [63:0] d, input int own,
                      input bit sv, input int sIdx, input logic [63:0] sD,
                      input bit mv, input bit mAck, input int mIdx, input logic [63:0] mD);
    @(negedge clk);
    reqValid = rv; reqKind = 2'(kind); reqAddr = {2'(idx), 3'(off)}; reqLen = 4'(len);
    reqData = d; reqOwner = 2'(own);
    rspValid = sv; rspLine = 2'(sIdx); rspData = sD;
    memRspValid = mv; memRspAck = mAck; memRspLine = 2'(mIdx); memRspData = mD;
    #1;
    gotAcc = reqAccept; gotRec = reqRecycle; gotRdy = rspReady;
    @(negedge clk);
    reqValid = 0; rspValid = 0; memRspValid = 0;
  endtask

  task automatic req(input int kind, input int idx, input int off, input int len,
                     input logic [63:0] d, input int own);
    step(1, kind, idx, off, len, d, own, 0, 0, '0, 0, 0, 0, '0);
  endtask

  task automatic rsp(input int idx, input logic [63:0] d);
    step(0, 0, 0, 0, 0, '0, 0, 1, idx, d, 0, 0, 0, '0);
  endtask

  task automatic mem(input bit ack, input int idx, input logic [63:0] d);
    step(0, 0, 0, 0, 0, '0, 0, 0, 0, '0, 1, ack, idx, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", 64'(outValid), 0);
    chk("R1 memReqValid", 64'(memReqValid), 0);
    chk("R1 reqAccept idle", 64'(reqAccept), 0);
    rstN = 1'b1;

    // R3: fetch path on every line, plus R9 recycle while in transient state
    for (int l = 0; l < 4; l++) begin
      req(1, l, 0, 0, '0, 0);
      chk("R3 read accepted", 64'(gotAcc), 1);
      chk("R3 fetch valid", 64'(memReqValid), 1);
      chk("R3 fetch is read", 64'(memReqWrite), 0);
      chk("R3 fetch line", 64'(memReqLine), 64'(l));
      chk("R3 fetch be zero", 64'(memReqBe), 0);
      req(0, l, 0, 0, '0, 1);
      chk("R9 transient recycled", 64'(gotRec), 1);
      mem(0, l, pat(8'(l + 3)));
      chk("R3 data out valid", 64'(outValid), 1);
      chk("R3 data kind", 64'(outKind), 0);
      chk("R3 data line", 64'(outLine), 64'(l));
      chk("R3 data payload", outData, pat(8'(l + 3)));
    end

    // R4/R5: partial writes over every offset and length
    for (int off = 0; off < LB; off++) begin
      for (int len = 0; len <= LB; len++) begin
        automatic int l = (off + len) % 4;
        automatic logic [63:0] d = pat(8'(off * 9 + len));
        automatic logic [7:0] be = expBe(off, len);
        req(2, l, off, len, d, 0);
        chk("R4 write accepted", 64'(gotAcc), 1);
        chk("R4 wb valid", 64'(memReqValid), 1);
        chk("R4 wb is write", 64'(memReqWrite), 1);
        chk("R4 wb line", 64'(memReqLine), 64'(l));
        chk("R5 byte enables", 64'(memReqBe), 64'(be));
        chk("R4 wb masked data", memReqData, maskBytes(d, be, '0));
        chk("R4 no response at accept", 64'(outValid), 0);
        mem(1, l, '0);
        chk("R4 ack valid", 64'(outValid), 1);
        chk("R4 ack kind", 64'(outKind), 1);
        chk("R4 ack line", 64'(outLine), 64'(l));
      end
    end

    // R2: ownership
    req(0, 1, 0, 0, '0, 2);
    chk("R2 own accepted", 64'(gotAcc), 1);
    chk("R2 own silent", 64'(outValid | memReqValid), 0);
    req(0, 1, 0, 0, '0, 3);
    chk("R2 own on M recycled", 64'(gotRec), 1);

    // R6: read of a modified line
    req(1, 1, 0, 0, '0, 0);
    chk("R6 read on M accepted", 64'(gotAcc), 1);
    chk("R6 inv kind", 64'(outKind), 2);
    chk("R6 inv valid", 64'(outValid), 1);
    chk("R6 inv dest", 64'(outDest), 2);
    chk("R6 inv line", 64'(outLine), 1);
    chk("R6 no fetch", 64'(memReqValid), 0);
    rsp(1, pat(8'h40));
    chk("R6 rsp taken", 64'(gotRdy), 1);
    chk("R6 data forwarded", outData, pat(8'h40));
    chk("R6 data kind", 64'(outKind), 0);
    chk("R6 full wb be", 64'(memReqBe), 64'hff);
    chk("R6 full wb data", memReqData, pat(8'h40));
    chk("R6 wb write", 64'(memReqWrite), 1);
    mem(1, 1, '0);
    chk("R6 ack silent", 64'(outValid), 0);
    req(0, 1, 0, 0, '0, 1);
    chk("R6 line back to I", 64'(gotAcc), 1);

    // R7/R8: write to modified line with single buffer
    req(0, 2, 0, 0, '0, 3);
    req(2, 1, 2, 3, pat(8'h80), 0);
    chk("R7 write on M accepted", 64'(gotAcc), 1);
    chk("R7 inv dest", 64'(outDest), 1);
    chk("R7 inv kind", 64'(outKind), 2);
    req(2, 2, 0, 8, pat(8'h90), 0);
    chk("R8 busy buffer recycles", 64'(gotRec), 1);
    rsp(1, pat(8'h10));
    chk("R7 merged wb data", memReqData, maskBytes(pat(8'h80), expBe(2, 3), pat(8'h10)));
    chk("R7 merged wb be", 64'(memReqBe), 64'hff);
    chk("R7 no output on recall", 64'(outValid), 0);
    mem(1, 1, '0);
    chk("R7 ack kind", 64'(outKind), 1);
    chk("R7 ack valid", 64'(outValid), 1);
    req(2, 2, 6, 5, pat(8'h90), 0);
    chk("R8 accepted after free", 64'(gotAcc), 1);
    chk("R8 inv dest", 64'(outDest), 3);
    rsp(2, pat(8'h22));
    chk("R7 clipped merge", memReqData, maskBytes(pat(8'h90), 8'hc0, pat(8'h22)));
    mem(1, 2, '0);
    chk("R7 second ack", 64'(outKind), 1);

    // R11 and R9: unexpected responses and unused code
    rsp(0, pat(8'h55));
    chk("R11 stray rsp consumed", 64'(gotRdy), 1);
    chk("R11 stray rsp silent", 64'(outValid | memReqValid), 0);
    mem(1, 0, '0);
    chk("R11 stray mem silent", 64'(outValid | memReqValid), 0);
    req(3, 0, 0, 0, '0, 0);
    chk("R9 unused code recycled", 64'(gotRec), 1);
    req(0, 0, 0, 0, '0, 2);
    chk("R11 line still I", 64'(gotAcc), 1);
    req(1, 0, 0, 0, '0, 0);
    chk("R11 read on M accepted", 64'(gotAcc), 1);
    chk("R11 inv dest", 64'(outDest), 2);
    rsp(0, pat(8'h66));
    mem(1, 0, '0);

    // R10: same-cycle collisions
    req(1, 0, 0, 0, '0, 0);
    req(0, 1, 0, 0, '0, 0);
    step(1, 1, 1, 0, 0, '0, 0, 0, 0, '0, 1, 0, 0, pat(8'h31));
    chk("R10 request recycled by mem output", 64'(gotRec), 1);
    chk("R10 mem data wins", outData, pat(8'h31));
    chk("R10 mem data line", 64'(outLine), 0);
    req(1, 1, 0, 0, '0, 0);
    chk("R10 retry accepted", 64'(gotAcc), 1);
    req(1, 2, 0, 0, '0, 0);
    step(0, 0, 0, 0, 0, '0, 0, 1, 1, pat(8'h77), 1, 0, 2, pat(8'h32));
    chk("R10 owner rsp stalled", 64'(gotRdy), 0);
    chk("R10 mem data out", outData, pat(8'h32));
    chk("R10 no wb while stalled", 64'(memReqValid), 0);
    step(1, 2, 3, 0, 8, pat(8'h01), 0, 1, 1, pat(8'h77), 0, 0, 0, '0);
    chk("R10 owner rsp taken", 64'(gotRdy), 1);
    chk("R10 write recycled by mem port", 64'(gotRec), 1);
    chk("R10 wb is recall", memReqData, pat(8'h77));
    chk("R10 wb line", 64'(memReqLine), 1);
    chk("R10 recall data out", outData, pat(8'h77));
    mem(1, 1, '0);
    req(2, 3, 0, 8, pat(8'h01), 0);
    chk("R10 write retry accepted", 64'(gotAcc), 1);
    mem(1, 3, '0);
    chk("R10 final ack", 64'(outKind), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule